// File: doc/BRIEF.md
# Memory-Map Chip-Select Decoder with Wait-State

This block is the glue logic between a small 8/16-bit processor and its memories and peripherals. It looks at address lines A16 down to A7, a valid-address qualifier and the read/not-write line. From these it drives active-low selects for RAM, ROM and seven 128-byte I/O windows, and an active-low wait-state enable. The address decode is purely combinational, so each select follows its inputs with no clock latency.

A single registered stage turns the wait-state enable into a ready output for the processor. Ready goes low for exactly one clock when a slow access begins. It stays high while that access continues and until a new slow access starts.

In bank 0 the map is as follows. The bottom 48 KiB is RAM. The next 1 KiB holds the I/O windows. The rest of the $C000 page block above that is RAM. ROM runs from $D000 to the top of the bank. When A16 is high, RAM is selected across the whole of bank 1.

Top module: `memmap_decoder`

## Requirements
- R1: When `addr_valid` is 0, every select and `wait_en_n` is 1, for any address and any `rd_wr_n`.
- R2: With `addr_valid` at 1, `ram_sel_n` is 0 exactly for $000000-$00BFFF, $00C400-$00CFFF and $010000-$01FFFF. A16 = `addr_hi[9]`, and A15..A7 = `addr_hi[8:0]`.
- R3: With `addr_valid` at 1 in bank 0, the addresses $C000-$C37F select `io_sel_n[k]`, where k = (address - $C000) / 128 and k runs from 0 to 6. The windows, in order, are serial A, serial B, quad-UART status, clock, expansion A, expansion B and expansion C.
- R4: An access to $00C380-$00C3FF asserts no select and no wait-state enable.
- R5: `rom_sel_n` is 0 only for $00D000-$00FFFF with `addr_valid` = 1 and `rd_wr_n` = 1. A write to that range selects nothing.
- R6: `wait_en_n` is 0 exactly when ROM or an I/O window is selected. It is never 0 for RAM, and never 0 for a write to the ROM range.
- R7: `rd_wr_n` has no effect on any output for addresses outside the ROM range.
- R8: All selects are active low, and at most one of the nine selects is 0 for any input combination.
- R9: `ready` is 0 for exactly one clock, in the cycle after the first cycle in which `wait_en_n` is 0. It then stays 1 until `wait_en_n` has returned to 1 and fallen again.
- R10: While `rst_n` is 0, `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the ready stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_hi | input | 10 | Address lines A16..A7 |
| addr_valid | input | 1 | High when the address bus holds a valid address |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| ram_sel_n | output | 1 | RAM select, active low |
| rom_sel_n | output | 1 | ROM select, active low |
| io_sel_n | output | 7 | I/O window selects, active low, indexed by window |
| wait_en_n | output | 1 | Wait-state enable, active low |
| ready | output | 1 | Processor ready, low for one clock per slow access |

## Verification
On every cycle, the bound checker enforces the following:
- the valid-address gating;
- the rule of at most one active select;
- the rule that a ROM write selects nothing;
- the agreement between the wait-state enable and the ROM and I/O selects;
- the one-clock width of every low pulse on ready.

The checker cannot tell whether the correct region was chosen for a given address. The bench shows this by sweeping all 4096 input combinations against a map computed from the address arithmetic. Only directed sequences show that a long slow access produces a single ready pulse, that a RAM access produces none, and that a new pulse needs the wait-state enable to rise and fall again.

// File: rtl/memmap_decoder.sv
module memmap_decoder #(
  parameter int PAGE_W     = 9,
  parameter int IO_BASE    = 384,
  parameter int IO_WINDOWS = 7,
  parameter int ROM_BASE   = 416
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PAGE_W:0]       addr_hi,
  input  logic                  addr_valid,
  input  logic                  rd_wr_n,
  output logic                  ram_sel_n,
  output logic                  rom_sel_n,
  output logic [IO_WINDOWS-1:0] io_sel_n,
  output logic                  wait_en_n,
  output logic                  ready
);
  localparam int SLOT_W  = $clog2(IO_WINDOWS + 1);
  localparam int IO_SPAN = 1 << SLOT_W;
  localparam logic [PAGE_W-1:0] IO_LO  = PAGE_W'(IO_BASE);
  localparam logic [PAGE_W-1:0] IO_HI  = PAGE_W'(IO_BASE + IO_SPAN);
  localparam logic [PAGE_W-1:0] ROM_LO = PAGE_W'(ROM_BASE);

  logic              upper_bank;
  logic [PAGE_W-1:0] page;
  logic [SLOT_W-1:0] slot;
  logic              in_io, in_rom, rom_hit, io_hit, slow, slow_q;

  assign upper_bank = addr_hi[PAGE_W];
  assign page       = addr_hi[PAGE_W-1:0];
  assign slot       = page[SLOT_W-1:0];

  assign in_io  = !upper_bank && page >= IO_LO && page < IO_HI;
  assign in_rom = !upper_bank && page >= ROM_LO;

  assign ram_sel_n = ~(addr_valid && !in_io && !in_rom);
  assign rom_hit   = addr_valid && in_rom && rd_wr_n;
  assign rom_sel_n = ~rom_hit;

  for (genvar i = 0; i < IO_WINDOWS; i++) begin : g_win
    assign io_sel_n[i] = ~(addr_valid && in_io && slot == SLOT_W'(i));
  end

  assign io_hit    = ~&io_sel_n;
  assign slow      = rom_hit || io_hit;
  assign wait_en_n = ~slow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= 1'b0;
      ready  <= 1'b1;
    end else begin
      slow_q <= slow;
      ready  <= ~(slow && !slow_q);
    end
  end
endmodule

module memmap_decoder_chk #(
  parameter int IO_WINDOWS = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  addr_valid,
  input logic                  rd_wr_n,
  input logic                  ram_sel_n,
  input logic                  rom_sel_n,
  input logic [IO_WINDOWS-1:0] io_sel_n,
  input logic                  wait_en_n,
  input logic                  ready
);
  // R1
  gate_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> (ram_sel_n && rom_sel_n && &io_sel_n && wait_en_n));
  // R8
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{ram_sel_n, rom_sel_n, io_sel_n}));
  // R5
  rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_wr_n |-> rom_sel_n);
  // R6
  wait_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_en_n == (!rom_sel_n || !(&io_sel_n)));
  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready);
  // R9
  ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(!wait_en_n));
endmodule

bind memmap_decoder memmap_decoder_chk #(.IO_WINDOWS(IO_WINDOWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .rd_wr_n(rd_wr_n),
  .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n), .io_sel_n(io_sel_n),
  .wait_en_n(wait_en_n), .ready(ready)
);

// File: tb/memmap_decoder_test.sv
module memmap_decoder_test;
  logic       clk = 0, rst_n = 0, addr_valid = 0, rd_wr_n = 1;
  logic [9:0] addr_hi = '0;
  logic       ram_sel_n, rom_sel_n, wait_en_n, ready;
  logic [6:0] io_sel_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  memmap_decoder uut (.clk(clk), .rst_n(rst_n), .addr_hi(addr_hi),
    .addr_valid(addr_valid), .rd_wr_n(rd_wr_n), .ram_sel_n(ram_sel_n),
    .rom_sel_n(rom_sel_n), .io_sel_n(io_sel_n), .wait_en_n(wait_en_n),
    .ready(ready));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (addr_hi=%0h valid=%0b rw=%0b)",
               req, act, exp, addr_hi, addr_valid, rd_wr_n);
    end
  endtask

  task automatic drive(logic [9:0] a, logic v, logic rw);
    @(negedge clk);
    addr_hi = a; addr_valid = v; rd_wr_n = rw;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 ready in reset", ready, 1);
    check("R1 selects in reset", {ram_sel_n, rom_sel_n, io_sel_n, wait_en_n}, 10'h3ff);
    rst_n = 1;

    for (int c = 0; c < 4096; c++) begin
      int addr, pg;
      bit hi, v, rw, ram, rom;
      int io;
      drive(c[9:0], c[10], c[11]);
      #1;
      hi = c[9]; pg = c & 511; v = c[10]; rw = c[11];
      addr = (hi ? 32'h10000 : 0) + pg * 128;
      ram = v && (hi || addr < 32'hC000 || (addr >= 32'hC400 && addr < 32'hD000));
      rom = v && !hi && addr >= 32'hD000 && rw;
      io = 7'h7f;
      if (v && !hi && addr >= 32'hC000 && addr < 32'hC380)
        io = io & ~(1 << ((addr - 32'hC000) / 128));
      if (!v) check("R1 gated outputs", {ram_sel_n, rom_sel_n, io_sel_n, wait_en_n}, 10'h3ff);
      check("R2 ram select", ram_sel_n, !ram);
      check("R5 rom select", rom_sel_n, !rom);
      check(addr >= 32'hC380 && addr < 32'hC400 && !hi ? "R4 undecoded window" : "R3 io windows",
            io_sel_n, io);
      check("R6 wait enable", wait_en_n, !(rom || io != 7'h7f));
      check("R8 at most one select",
            $countones(~{ram_sel_n, rom_sel_n, io_sel_n}) <= 1, 1);
    end

    for (int k = 0; k < 1024; k++) begin
      logic [9:0] a = k[9:0];
      logic r1, r0;
      logic [6:0] i1, i0;
      logic w1, w0;
      if (!a[9] && a[8:0] >= 9'd416) continue;
      drive(a, 1, 1); #1; r1 = ram_sel_n; i1 = io_sel_n; w1 = wait_en_n;
      drive(a, 1, 0); #1; r0 = ram_sel_n; i0 = io_sel_n; w0 = wait_en_n;
      check("R7 rw no effect", {r0, i0, w0}, {r1, i1, w1});
    end

    drive(10'h000, 0, 1);
    drive(10'h000, 0, 1);
    drive(10'd448, 1, 1);
    @(negedge clk); check("R9 ready low after rom start", ready, 0);
    @(negedge clk); check("R9 ready back high", ready, 1);
    repeat (3) @(negedge clk);
    check("R9 no second pulse in long access", ready, 1);
    drive(10'd384, 1, 0);
    @(negedge clk); check("R9 no pulse without rise", ready, 1);
    drive(10'd384, 0, 0);
    drive(10'd385, 1, 0);
    @(negedge clk); check("R9 ready low after io start", ready, 0);
    @(negedge clk); check("R9 ready high after io pulse", ready, 1);
    drive(10'h000, 1, 1);
    drive(10'h200, 1, 0);
    @(negedge clk); check("R9 no pulse for ram", ready, 1);
    drive(10'd448, 1, 0);
    @(negedge clk); check("R6 R9 no pulse on rom write", ready, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule